// File: doc/BRIEF.md
# System Power and Safety Sequencer

This block supervises a multi-slot controller chassis. It cleans up three front-panel buttons (power, STOP, Enable), tells a brief power press apart from a long hold, and watches supply, power-good, thermal and per-slot overcurrent status. From these it runs a small supervisory state machine. The machine decides when the adapter cards see a carrier-ready signal and when each slot's output-enable request is passed through. It also shows its current state as a colour on the power button's RGB indicator.

Faults come in two classes, and each is cleared by a different button. A failing supply, a lost power-good or an over-temperature flag is treated as a hard fault. Only a power-button press clears it, and that press leaves the system off. A STOP request, either from the panel button or from the normally-closed external STOP line, is a soft fault. Enable clears it once the stop has gone away. A slot whose rail reports overcurrent stays disabled until the block is reset, which models a full power cycle.

The status inputs (`vin_ok`, `pgood`, `overtemp`, `slot_oc`, `slot_oe_in`) are taken to be synchronous to `clk`. Each button passes through a synchronizer and a debounce filter. The external stop line passes through a two-stage synchronizer only, so it is not delayed by the debounce time.

Top module: `pwr_safety_seq`

## Requirements
- R1: A change on any button input that lasts fewer than DEB_CYCLES consecutive clocks after synchronization is ignored; a 2-cycle pulse on the power button while off leaves the indicator blue.
- R2: In the off state, a power press moves the block to a start-up state (cyan). It moves on to normal operation (green) only when `vin_ok`=1, `pgood`=1 and `overtemp`=0. It stays cyan while these conditions are unhealthy.
- R3: In normal operation, a power press released before HOLD_CYCLES clocks has no effect.
- R4: In normal operation, holding the power button for HOLD_CYCLES clocks enters a shut-down state (magenta) while the button is held. Releasing the button then leads to off (blue).
- R5: `carrier_ready` is 1 only in normal operation with healthy status. Loss of `vin_ok` or `pgood`, or `overtemp`=1, during operation enters the hard-fault state (red) and drops `carrier_ready` and all output-enables.
- R6: The hard fault stays latched after the status recovers, and Enable does not clear it. A power press shows yellow while held, and its release leads to off (blue).
- R7: An active stop (`ext_stop_n`=0 or a debounced `fp_stop_btn`=1) during operation enters the soft-fault state (white). Enable is ignored while the stop is still active. Removing the stop alone does not leave white. Enable after the stop has been removed returns to green.
- R8: `slot_oe_out[i]` equals `slot_oe_in[i]` only in normal operation, with no stop active and slot i not overcurrent-latched. Otherwise it is 0.
- R9: A 1 on `slot_oc[i]` for one clock latches slot i disabled. The latch survives soft power-off and power-on and is cleared only by `rst_n`.
- R10: `ext_stop_n` going low forces every `slot_oe_out` to 0 no later than the second rising clock edge after the change, before the state register reacts.
- R11: `led_rgb` is {red,green,blue}: off 001, start-up 011, normal 010, shut-down 101, hard fault 100, hard-fault acknowledge 110, soft fault 111.
- R12: After reset the block is off: `led_rgb`=001, `carrier_ready`=0, all `slot_oe_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (full power cycle) |
| pwr_btn | input | 1 | Power push button, 1 = pressed |
| fp_stop_btn | input | 1 | Front-panel STOP button, 1 = pressed |
| en_btn | input | 1 | Front-panel Enable button, 1 = pressed |
| ext_stop_n | input | 1 | Normally-closed external stop, 0 = stop |
| vin_ok | input | 1 | Input supply within range |
| pgood | input | 1 | Combined power-good of the on-board rails |
| overtemp | input | 1 | Thermal alarm, 1 = too hot |
| slot_oc | input | N_SLOTS | Per-slot rail overcurrent flags |
| slot_oe_in | input | N_SLOTS | Per-slot output-enable requests from the slot logic |
| carrier_ready | output | 1 | Carrier-ready to all adapter cards |
| slot_oe_out | output | N_SLOTS | Gated per-slot output-enables to the adapter cards |
| led_rgb | output | 3 | Power button indicator {red,green,blue} |

## Verification
The bench goes after the places where the two fault classes and the two press lengths meet. If a design cleared the hard fault with Enable or recovered by itself, the bench would see green where red is expected. If it returned from white as soon as the stop went away, the bench would see green before Enable is pressed. If it measured the hold wrongly, a short press in operation would switch the system off, or a long one would not. The bench also checks that an overcurrent latch survives a soft power cycle, where a design that cleared it on power-off would re-enable the slot. It checks that the output-enables fall two edges after the external stop changes, where a design that gated them only through the state register would be one clock late. A glitch on the power button shows whether the debounce filter is present.

// File: rtl/pss_pkg.sv
// Package: shared state encoding and indicator colours for the power and
// safety sequencer. Assumes led bits are ordered {red, green, blue}.
package pss_pkg;

    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_START = 3'd1,
        S_RUN   = 3'd2,
        S_SHUT  = 3'd3,
        S_HARD  = 3'd4,
        S_ACK   = 3'd5,
        S_SOFT  = 3'd6
    } seq_state_t;

    localparam logic [2:0] C_BLUE    = 3'b001;
    localparam logic [2:0] C_CYAN    = 3'b011;
    localparam logic [2:0] C_GREEN   = 3'b010;
    localparam logic [2:0] C_MAGENTA = 3'b101;
    localparam logic [2:0] C_RED     = 3'b100;
    localparam logic [2:0] C_YELLOW  = 3'b110;
    localparam logic [2:0] C_WHITE   = 3'b111;

    // Maps a sequencer state to the colour shown on the power button.
    function automatic logic [2:0] state_colour(seq_state_t s);
        case (s)
            S_OFF:   return C_BLUE;
            S_START: return C_CYAN;
            S_RUN:   return C_GREEN;
            S_SHUT:  return C_MAGENTA;
            S_HARD:  return C_RED;
            S_ACK:   return C_YELLOW;
            S_SOFT:  return C_WHITE;
            default: return C_RED;
        endcase
    endfunction

endpackage

// File: rtl/pss_debounce.sv
// Module: two-flop synchronizer followed by a debounce filter.
// The filtered level follows the synchronized input only after the input
// has differed from it for DEB_CYCLES consecutive clocks.
// Assumes DEB_CYCLES >= 2. Reset level is 0 (button released).
module pss_debounce #(
    parameter int DEB_CYCLES = 500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Synchronize the raw input and filter it through the stability counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            cnt_q  <= '0;
            level  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == level) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                level <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R1: the filtered level only moves when the counter has run out.
    a_r1_settled_change: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/pss_hold_timer.sv
// Module: classifies the debounced power button. press_evt pulses on the
// cycle the level rises; long_evt pulses once when the button has been held
// for HOLD_CYCLES clocks. The count saturates so a long press fires once.
// Assumes HOLD_CYCLES >= 2.
module pss_hold_timer #(
    parameter int HOLD_CYCLES = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic press_evt,
    output logic long_evt
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] FIRE = CW'(HOLD_CYCLES - 1);
    localparam logic [CW-1:0] SAT  = CW'(HOLD_CYCLES);

    logic          level_d;
    logic [CW-1:0] cnt_q;

    // Remember the previous level and time how long the button is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= 1'b0;
            cnt_q   <= '0;
        end else begin
            level_d <= level;
            if (!level)
                cnt_q <= '0;
            else if (cnt_q != SAT)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Decode the rising edge and the terminal count.
    always_comb begin
        press_evt = level && !level_d;
        long_evt  = level && (cnt_q == FIRE);
    end

    // R4: a long hold is only reported while the button is still down.
    a_r4_long_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        long_evt |-> (level && $past(level)));

endmodule

// File: rtl/pss_slot_gate.sv
// Module: per-slot output-enable gating with sticky overcurrent latches.
// A slot's request passes only while allow is high and the slot has never
// reported overcurrent since reset. An overcurrent flag blocks its slot in
// the same cycle it appears and from then on through the latch.
module pss_slot_gate #(
    parameter int N_SLOTS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               allow,
    input  logic [N_SLOTS-1:0] oc_in,
    input  logic [N_SLOTS-1:0] oe_in,
    output logic [N_SLOTS-1:0] oe_out
);
    logic [N_SLOTS-1:0] oc_lat;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        // Latch the overcurrent flag of this slot until reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                oc_lat[i] <= 1'b0;
            else if (oc_in[i])
                oc_lat[i] <= 1'b1;
        end

        // Forward this slot's request only when allowed and not tripped.
        always_comb begin
            oe_out[i] = oe_in[i] && allow && !oc_lat[i] && !oc_in[i];
        end

        // R9: once tripped, a slot stays tripped until reset.
        a_r9_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            oc_lat[i] |=> oc_lat[i]);

        // R9: a tripped slot never reaches its adapter card.
        a_r9_tripped_blocked: assert property (@(posedge clk) disable iff (!rst_n)
            $past(oc_in[i]) |-> !oe_out[i]);
    end

endmodule

// File: rtl/pwr_safety_seq.sv
// Module: top of the power and safety sequencer. Debounces the three panel
// buttons, classifies power presses, runs the supervisory state machine and
// drives carrier-ready, the gated slot output-enables and the RGB indicator.
// Assumes vin_ok, pgood, overtemp, slot_oc and slot_oe_in are synchronous to
// clk; ext_stop_n is asynchronous and is synchronized but not debounced.
module pwr_safety_seq
    import pss_pkg::*;
#(
    parameter int DEB_CYCLES  = 500_000,
    parameter int HOLD_CYCLES = 100_000_000,
    parameter int N_SLOTS     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_btn,
    input  logic               fp_stop_btn,
    input  logic               en_btn,
    input  logic               ext_stop_n,
    input  logic               vin_ok,
    input  logic               pgood,
    input  logic               overtemp,
    input  logic [N_SLOTS-1:0] slot_oc,
    input  logic [N_SLOTS-1:0] slot_oe_in,
    output logic               carrier_ready,
    output logic [N_SLOTS-1:0] slot_oe_out,
    output logic [2:0]         led_rgb
);
    localparam int N_BTN = 3;
    localparam int B_PWR = 0;
    localparam int B_STP = 1;
    localparam int B_EN  = 2;

    logic [N_BTN-1:0] btn_raw;
    logic [N_BTN-1:0] btn_lvl;
    logic             pwr_press;
    logic             pwr_long;
    logic             en_d;
    logic             en_press;
    logic [1:0]       xstop_q;
    logic             stop_act;
    logic             healthy;
    logic             allow_oe;
    seq_state_t       state_q;
    seq_state_t       state_d;

    assign btn_raw = {en_btn, fp_stop_btn, pwr_btn};

    for (genvar b = 0; b < N_BTN; b++) begin : g_btn
        pss_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (btn_raw[b]),
            .level (btn_lvl[b])
        );
    end

    pss_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (btn_lvl[B_PWR]),
        .press_evt (pwr_press),
        .long_evt  (pwr_long)
    );

    // Synchronize the external stop (reset to the safe, stopped value) and
    // keep the previous Enable level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xstop_q <= 2'b00;
            en_d    <= 1'b0;
        end else begin
            xstop_q <= {xstop_q[0], ext_stop_n};
            en_d    <= btn_lvl[B_EN];
        end
    end

    // Combine the stop sources, the health status and the Enable edge.
    always_comb begin
        stop_act = !xstop_q[1] || btn_lvl[B_STP];
        healthy  = vin_ok && pgood && !overtemp;
        en_press = btn_lvl[B_EN] && !en_d;
    end

    // Next-state decision of the supervisory machine; hard faults win over
    // stops, stops win over the power-off hold.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_OFF:   if (pwr_press) state_d = S_START;
            S_START: if (stop_act) state_d = S_SOFT;
                     else if (healthy) state_d = S_RUN;
            S_RUN:   if (!healthy) state_d = S_HARD;
                     else if (stop_act) state_d = S_SOFT;
                     else if (pwr_long) state_d = S_SHUT;
            S_SHUT:  if (!btn_lvl[B_PWR]) state_d = S_OFF;
            S_HARD:  if (pwr_press) state_d = S_ACK;
            S_ACK:   if (!btn_lvl[B_PWR]) state_d = S_OFF;
            S_SOFT:  if (!healthy) state_d = S_HARD;
                     else if (en_press && !stop_act) state_d = S_RUN;
            default: state_d = S_HARD;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_OFF;
        else
            state_q <= state_d;
    end

    // Outputs: carrier-ready, permission for the slot gates and colour.
    always_comb begin
        carrier_ready = (state_q == S_RUN) && healthy;
        allow_oe      = (state_q == S_RUN) && healthy && !stop_act;
        led_rgb       = state_colour(state_q);
    end

    pss_slot_gate #(.N_SLOTS(N_SLOTS)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .allow  (allow_oe),
        .oc_in  (slot_oc),
        .oe_in  (slot_oe_in),
        .oe_out (slot_oe_out)
    );

    // R6: the hard fault stays until a power press acknowledges it.
    a_r6_hard_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HARD && !pwr_press) |=> (state_q == S_HARD));

    // R4, R6: off is only reached through shut-down or acknowledge.
    a_r4_off_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF && $past(state_q) != S_OFF)
            |-> ($past(state_q) == S_SHUT || $past(state_q) == S_ACK));

    // R5: carrier-ready never coexists with a failed status input.
    a_r5_ready_healthy: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_ready |-> (vin_ok && pgood && !overtemp));

    // R10: a synchronized external stop blocks every slot at once.
    a_r10_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !xstop_q[1] |-> (slot_oe_out == '0));

    // R7: soft fault is only left towards normal operation on an Enable edge.
    a_r7_soft_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == S_SOFT && state_q == S_RUN) |-> $past(en_press));

    // R8: outputs are only ever a subset of the requests.
    a_r8_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_oe_out & ~slot_oe_in) == '0);

    // R11: the indicator always carries exactly one defined colour code.
    a_r11_colour_valid: assert property (@(posedge clk) disable iff (!rst_n)
        led_rgb != 3'b000);

endmodule

// File: tb/tb_pwr_safety_seq.sv
// Scoreboard bench: the driver applies stimulus and pushes the expected
// {colour, carrier_ready, slot_oe_out} into a queue; the monitor pops and
// compares at the falling edge.
module tb_pwr_safety_seq;
    localparam int NS = 5;
    localparam logic [2:0] BLUE = 3'b001, CYAN = 3'b011, GREEN = 3'b010,
        MAGENTA = 3'b101, RED = 3'b100, YELLOW = 3'b110, WHITE = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_btn = 1'b0, fp_stop_btn = 1'b0, en_btn = 1'b0;
    logic ext_stop_n = 1'b1, vin_ok = 1'b1, pgood = 1'b1, overtemp = 1'b0;
    logic [NS-1:0] slot_oc = '0;
    logic [NS-1:0] slot_oe_in = '1;
    logic carrier_ready;
    logic [NS-1:0] slot_oe_out;
    logic [2:0] led_rgb;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    pwr_safety_seq #(.DEB_CYCLES(4), .HOLD_CYCLES(60), .N_SLOTS(NS)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_btn(pwr_btn), .fp_stop_btn(fp_stop_btn),
        .en_btn(en_btn), .ext_stop_n(ext_stop_n), .vin_ok(vin_ok), .pgood(pgood),
        .overtemp(overtemp), .slot_oc(slot_oc), .slot_oe_in(slot_oe_in),
        .carrier_ready(carrier_ready), .slot_oe_out(slot_oe_out), .led_rgb(led_rgb)
    );

    // Monitor: compare the outputs with the oldest expected item.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({led_rgb, carrier_ready, slot_oe_out} !== e) begin
                    fails++;
                    $display("FAIL %s: actual rgb=%b rdy=%b oe=%b expected rgb=%b rdy=%b oe=%b",
                        t, led_rgb, carrier_ready, slot_oe_out, e[8:6], e[5], e[4:0]);
                end
            end
        end
    end

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(logic [2:0] rgb, logic rdy, logic [NS-1:0] oe, string t);
        exp_q.push_back({rgb, rdy, oe});
        tag_q.push_back(t);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // which: 0 power, 1 panel stop, 2 enable
    task automatic set_btn(int which, logic v);
        case (which)
            0: pwr_btn = v;
            1: fp_stop_btn = v;
            default: en_btn = v;
        endcase
    endtask

    task automatic press(int which, int cyc);
        @(negedge clk);
        set_btn(which, 1'b1);
        settle(cyc);
        set_btn(which, 1'b0);
        settle(20);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    // Driver.
    initial begin
        settle(5);
        rst_n = 1'b1;
        settle(3);
        expect_out(BLUE, 1'b0, 5'b00000, "R12 reset state off");

        // R1: a 2-cycle glitch on power is filtered
        @(negedge clk); pwr_btn = 1'b1; settle(2); pwr_btn = 1'b0; settle(20);
        expect_out(BLUE, 1'b0, 5'b00000, "R1 glitch ignored");

        // R2: power-on waits in cyan while unhealthy
        pgood = 1'b0;
        press(0, 15);
        expect_out(CYAN, 1'b0, 5'b00000, "R2 start-up held while unhealthy");
        pgood = 1'b1;
        settle(3);
        expect_out(GREEN, 1'b1, 5'b11111, "R2 running once healthy");

        // R3: short press in operation does nothing
        press(0, 15);
        expect_out(GREEN, 1'b1, 5'b11111, "R3 short press ignored");

        // R8: requests forwarded bit by bit
        slot_oe_in = 5'b10110;
        settle(1);
        expect_out(GREEN, 1'b1, 5'b10110, "R8 requests forwarded");
        slot_oe_in = '1;

        // R9: one-cycle overcurrent on slot 1 latches
        @(negedge clk); slot_oc = 5'b00010; @(negedge clk); slot_oc = '0;
        settle(3);
        expect_out(GREEN, 1'b1, 5'b11101, "R9 slot 1 latched off");

        // R4: long hold -> magenta while held, blue after release
        @(negedge clk); pwr_btn = 1'b1; settle(80);
        expect_out(MAGENTA, 1'b0, 5'b00000, "R4 shut-down while held");
        pwr_btn = 1'b0; settle(20);
        expect_out(BLUE, 1'b0, 5'b00000, "R4 off after release");

        // R9: latch survives the soft power cycle
        press(0, 15);
        expect_out(GREEN, 1'b1, 5'b11101, "R9 latch survives power-off");

        // R10: external stop gates outputs by the second edge
        @(negedge clk); ext_stop_n = 1'b0;
        settle(2);
        checks++;
        if (slot_oe_out !== 5'b00000) begin
            fails++;
            $display("FAIL R10 stop gating: actual oe=%b expected oe=00000", slot_oe_out);
        end
        settle(3);
        expect_out(WHITE, 1'b0, 5'b00000, "R7 soft fault on external stop");

        // R7: Enable ignored while stopped; release alone does not recover
        press(2, 15);
        expect_out(WHITE, 1'b0, 5'b00000, "R7 enable ignored during stop");
        ext_stop_n = 1'b1; settle(10);
        expect_out(WHITE, 1'b0, 5'b00000, "R7 no recovery without enable");
        press(2, 15);
        expect_out(GREEN, 1'b1, 5'b11101, "R7 enable recovers");

        // R7: panel STOP button path
        @(negedge clk); fp_stop_btn = 1'b1; settle(15);
        expect_out(WHITE, 1'b0, 5'b00000, "R7 panel stop");
        fp_stop_btn = 1'b0; settle(20);
        press(2, 15);
        expect_out(GREEN, 1'b1, 5'b11101, "R7 enable after panel stop");

        // R5: over-temperature -> hard fault
        @(negedge clk); overtemp = 1'b1; settle(2);
        expect_out(RED, 1'b0, 5'b00000, "R5 hard fault on overtemp");
        overtemp = 1'b0; settle(5);
        expect_out(RED, 1'b0, 5'b00000, "R6 latched after recovery");
        press(2, 15);
        expect_out(RED, 1'b0, 5'b00000, "R6 enable ignored");

        // R6: acknowledge with power press
        @(negedge clk); pwr_btn = 1'b1; settle(15);
        expect_out(YELLOW, 1'b0, 5'b00000, "R6 acknowledge while held");
        pwr_btn = 1'b0; settle(20);
        expect_out(BLUE, 1'b0, 5'b00000, "R6 off after acknowledge");

        // R5: supply loss in operation
        press(0, 15);
        expect_out(GREEN, 1'b1, 5'b11101, "R2 power-on again");
        @(negedge clk); vin_ok = 1'b0; settle(2);
        expect_out(RED, 1'b0, 5'b00000, "R5 hard fault on supply loss");

        settle(5);
        finish_run();
    end

endmodule